// File: doc/BRIEF.md
# Vectored interrupt controller

This block collects interrupt requests from up to 32 peripheral lines and presents them to one processor through a small bank of 32-bit registers. Each line has a fixed sense, chosen when the block is built: rising edge, falling edge, active-high level or active-low level. Every line passes through a two-flop synchronizer. A detected event sets a latched status bit. Software writes ones to an acknowledge register to clear status bits.

An enable mask selects which latched requests count as pending. Software can load the mask whole, or set and clear single bits through two alias registers so that no read-modify-write is needed. The lowest-numbered pending line wins, and its index is returned by a vector register. A two-bit master control must be fully on (both bits set) before the block drives its single interrupt output or records new hardware events.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the status, enable and master registers read zero, the vector reads all ones and `irq_out` is low. The reset input is asynchronous and its release is synchronized to the clock.
- R2: A write to byte offset 8 loads the enable register. A read at offset 8 returns it.
- R3: A write to offset 16 sets the enable bits where the data has ones. A write to offset 20 clears the enable bits where the data has ones. Every other enable bit keeps its value.
- R4: A write to offset 12 clears each status bit (read at offset 0) whose data bit is one, unless the same line produces a new event in that cycle. Offset 12 reads zero.
- R5: An input with sense code 0 (rising edge) or 1 (falling edge) sets its status bit once per edge. The sense code for input i sits in bits [2i+1:2i] of `SENSE_MAP`. The status bit is readable after the third rising clock edge following the line change. Acknowledging the bit while the line stays at its new level leaves it clear.
- R6: An input with sense code 2 (high) or 3 (low) sets its status bit in every cycle its level is active. An acknowledge issued while the level is still active therefore leaves the bit set.
- R7: A read at offset 4 returns the pending set, which is the status bits ANDed with the enable bits.
- R8: A read at offset 24 returns the index of the lowest-numbered pending bit, or all ones when nothing is pending.
- R9: `irq_out` is high exactly when at least one bit is pending and the master register, written and read at offset 28 (bits 1:0), holds 3.
- R10: While the master register is not 3, hardware events set no status bits. Status bits already set are kept.
- R11: Writes to offsets 0, 4 and 24 change no state. Accesses whose two low address bits are not zero are ignored and read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_IN | Peripheral request lines, asynchronous |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with 32 inputs and a sense map that repeats rising, falling, high and low over each group of four inputs. Inputs 0 to 3 therefore cover every sense, and inputs 4 and 5 let two different edge types compete for the vector. Input 31 is an active-low level line, which exercises the top vector index and an enable set through the set-alias register. The master control is also stepped through values 1 and 2, which shows that events are dropped and that the output is gated while latched status is kept.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef enum logic [1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  // word index = byte address [4:2]
  localparam logic [2:0] WIDX_STATUS = 3'd0;
  localparam logic [2:0] WIDX_PEND   = 3'd1;
  localparam logic [2:0] WIDX_ENABLE = 3'd2;
  localparam logic [2:0] WIDX_ACK    = 3'd3;
  localparam logic [2:0] WIDX_ENSET  = 3'd4;
  localparam logic [2:0] WIDX_ENCLR  = 3'd5;
  localparam logic [2:0] WIDX_VECTOR = 3'd6;
  localparam logic [2:0] WIDX_MASTER = 3'd7;

  localparam logic [1:0] MASTER_ON = 2'b11;

endpackage

// File: rtl/vic_rst_sync.sv
module vic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb sh_d = {sh_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= sh_d;
  end

  assign rst_q_n = sh_q[1];
endmodule

// File: rtl/vic_sense_det.sv
module vic_sense_det
  import vic_pkg::*;
#(
  parameter sense_e SENSE = SENSE_HIGH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic hit
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= line;
      s2_q <= s1_q;
    end
  end

  generate
    if (SENSE == SENSE_RISE || SENSE == SENSE_FALL) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= s2_q;
      end
      if (SENSE == SENSE_RISE) begin : g_rise
        assign hit = s2_q & ~prev_q;
      end else begin : g_fall
        assign hit = ~s2_q & prev_q;
      end
    end else begin : g_level
      if (SENSE == SENSE_HIGH) begin : g_high
        assign hit = s2_q;
      end else begin : g_low
        assign hit = ~s2_q;
      end
    end
  endgenerate
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int NUM_IN = 32,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic [NUM_IN-1:0] req,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_IN = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter logic [2*NUM_IN-1:0] SENSE_MAP = {NUM_IN{SENSE_HIGH}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_lines,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic rst_q_n;
  logic [NUM_IN-1:0] hit;
  logic [NUM_IN-1:0] status_q, status_d, en_q, en_d, pend;
  logic [1:0]        mer_q, mer_d;
  logic              status_ce, en_ce, mer_ce;
  logic              aligned, mer_on, vec_found;
  logic [2:0]        widx;
  logic [IDX_W-1:0]  vec_idx;
  logic [DATA_W-1:0] vec_word;
  logic [NUM_IN-1:0] wmask;

  vic_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_det
      vic_sense_det #(.SENSE(sense_e'(SENSE_MAP[2*i +: 2]))) u_det (
        .clk  (clk),
        .rst_n(rst_q_n),
        .line (irq_lines[i]),
        .hit  (hit[i])
      );
    end
  endgenerate

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign widx    = bus_addr[4:2];
  assign wmask   = bus_wdata[NUM_IN-1:0];
  assign mer_on  = (mer_q == MASTER_ON);

  // next-state
  always_comb begin
    logic wr_ack, wr_en, wr_set, wr_clr, wr_mer;
    wr_ack = bus_wr && aligned && (widx == WIDX_ACK);
    wr_en  = bus_wr && aligned && (widx == WIDX_ENABLE);
    wr_set = bus_wr && aligned && (widx == WIDX_ENSET);
    wr_clr = bus_wr && aligned && (widx == WIDX_ENCLR);
    wr_mer = bus_wr && aligned && (widx == WIDX_MASTER);

    status_ce = wr_ack || (mer_on && (|hit));
    status_d  = (status_q & ~(wr_ack ? wmask : '0)) | (mer_on ? hit : '0);

    en_ce = wr_en || wr_set || wr_clr;
    if (wr_en)       en_d = wmask;
    else if (wr_set) en_d = en_q | wmask;
    else if (wr_clr) en_d = en_q & ~wmask;
    else             en_d = en_q;

    mer_ce = wr_mer;
    mer_d  = bus_wdata[1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      status_q <= '0;
      en_q     <= '0;
      mer_q    <= 2'b00;
    end else begin
      if (status_ce) status_q <= status_d;
      if (en_ce)     en_q     <= en_d;
      if (mer_ce)    mer_q    <= mer_d;
    end
  end

  assign pend = status_q & en_q;

  vic_prio_enc #(.NUM_IN(NUM_IN)) u_enc (
    .req  (pend),
    .found(vec_found),
    .idx  (vec_idx)
  );

  assign vec_word = vec_found ? DATA_W'(vec_idx) : '1;
  assign irq_out  = mer_on && (|pend);

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (widx)
        WIDX_STATUS: bus_rdata = DATA_W'(status_q);
        WIDX_PEND:   bus_rdata = DATA_W'(pend);
        WIDX_ENABLE: bus_rdata = DATA_W'(en_q);
        WIDX_VECTOR: bus_rdata = vec_word;
        WIDX_MASTER: bus_rdata = DATA_W'(mer_q);
        default:     bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NUM_IN = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NUM_IN-1:0] status,
  input logic [NUM_IN-1:0] en,
  input logic [1:0]        mer,
  input logic [NUM_IN-1:0] pend,
  input logic [DATA_W-1:0] vec,
  input logic              irq_out
);
  logic [NUM_IN-1:0] below;
  assign below = (NUM_IN'(1) << vec[IDX_W-1:0]) - NUM_IN'(1);

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(16)) |=>
      ((en & $past(bus_wdata[NUM_IN-1:0])) == $past(bus_wdata[NUM_IN-1:0])));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(20)) |=>
      ((en & $past(bus_wdata[NUM_IN-1:0])) == '0));

  // R4
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(12) && mer != 2'b11) |=>
      ((status & $past(bus_wdata[NUM_IN-1:0])) == '0));

  // R10
  no_set_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mer != 2'b11) |=> ((status & ~$past(status)) == '0));

  // R11
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(4) ||
                bus_addr == ADDR_W'(24))) |=> ($stable(en) && $stable(mer)));

  // R8
  vec_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '1) |-> (pend[vec[IDX_W-1:0]] && ((pend & below) == '0)));

  // R8
  vec_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (vec == '1));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mer == 2'b11 && pend != '0));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
  .NUM_IN(NUM_IN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .status   (status_q),
  .en       (en_q),
  .mer      (mer_q),
  .pend     (pend),
  .vec      (vec_word),
  .irq_out  (irq_out)
);

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;
  localparam int NI = 32;
  localparam logic [63:0] MAP = {8{8'hE4}}; // input i sense = i mod 4
  localparam logic [31:0] IDLE = 32'hAAAA_AAAA;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_LN = 2'd2, K_IRQ = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] lines = IDLE;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_out;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vec_irq_ctrl #(.NUM_IN(NI), .DATA_W(32), .ADDR_W(5), .SENSE_MAP(MAP)) uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [74:0] st(input logic [1:0] k, input logic [3:0] r,
      input logic [4:0] a, input logic [31:0] d, input logic [31:0] e);
    return {k, r, a, d, e};
  endfunction

  localparam int N = 73;
  localparam logic [74:0] TBL [N] = '{
    st(K_WR, 10, 28, 3, 0),                    // R10
    st(K_RD, 10, 28, 0, 3),                    // R10
    st(K_WR, 2, 8, 32'hF, 0),                  // R2
    st(K_RD, 2, 8, 0, 32'hF),                  // R2
    st(K_LN, 5, 0, 32'hAAAAAAAB, 0),           // R5 rise on 0
    st(K_RD, 5, 0, 0, 1),                      // R5
    st(K_RD, 7, 4, 0, 1),                      // R7
    st(K_RD, 8, 24, 0, 0),                     // R8
    st(K_IRQ, 9, 0, 0, 1),                     // R9
    st(K_WR, 4, 12, 1, 0),                     // R4
    st(K_RD, 5, 0, 0, 0),                      // R5 stays clear
    st(K_LN, 5, 0, 32'hAAAAAAA8, 0),           // R5 fall on 1
    st(K_RD, 5, 0, 0, 2),                      // R5
    st(K_RD, 8, 24, 0, 1),                     // R8
    st(K_LN, 6, 0, 32'hAAAAAAAE, 0),           // R6 high on 2
    st(K_RD, 6, 0, 0, 6),                      // R6
    st(K_RD, 8, 24, 0, 1),                     // R8
    st(K_WR, 4, 12, 2, 0),                     // R4
    st(K_RD, 4, 0, 0, 4),                      // R4
    st(K_WR, 6, 12, 4, 0),                     // R6 ack while active
    st(K_RD, 6, 0, 0, 4),                      // R6
    st(K_LN, 6, 0, IDLE, 0),                   // R6
    st(K_WR, 4, 12, 4, 0),                     // R4
    st(K_RD, 4, 0, 0, 0),                      // R4
    st(K_IRQ, 9, 0, 0, 0),                     // R9
    st(K_LN, 6, 0, 32'hAAAAAAA2, 0),           // R6 low on 3
    st(K_RD, 6, 0, 0, 8),                      // R6
    st(K_RD, 7, 4, 0, 8),                      // R7
    st(K_RD, 8, 24, 0, 3),                     // R8
    st(K_WR, 3, 20, 8, 0),                     // R3 clear alias
    st(K_RD, 3, 8, 0, 7),                      // R3
    st(K_RD, 7, 4, 0, 0),                      // R7
    st(K_RD, 8, 24, 0, 32'hFFFFFFFF),          // R8
    st(K_IRQ, 9, 0, 0, 0),                     // R9
    st(K_WR, 3, 16, 32'h30, 0),                // R3 set alias
    st(K_RD, 3, 8, 0, 32'h37),                 // R3
    st(K_LN, 6, 0, IDLE, 0),                   // R6
    st(K_WR, 4, 12, 8, 0),                     // R4
    st(K_RD, 4, 0, 0, 0),                      // R4
    st(K_LN, 8, 0, 32'hAAAAAA9A, 0),           // R8 edges on 4 and 5
    st(K_RD, 5, 0, 0, 32'h30),                 // R5
    st(K_RD, 8, 24, 0, 4),                     // R8
    st(K_WR, 4, 12, 32'h10, 0),                // R4
    st(K_RD, 8, 24, 0, 5),                     // R8
    st(K_WR, 4, 12, 32'h20, 0),                // R4
    st(K_RD, 8, 24, 0, 32'hFFFFFFFF),          // R8
    st(K_LN, 6, 0, 32'h2AAAAA9A, 0),           // R6 low on 31
    st(K_RD, 6, 0, 0, 32'h80000000),           // R6
    st(K_RD, 7, 4, 0, 0),                      // R7
    st(K_WR, 3, 16, 32'h80000000, 0),          // R3
    st(K_RD, 8, 24, 0, 32'h1F),                // R8
    st(K_LN, 6, 0, IDLE, 0),                   // R6
    st(K_WR, 4, 12, 32'hFFFFFFFF, 0),          // R4
    st(K_RD, 4, 0, 0, 0),                      // R4
    st(K_WR, 11, 0, 32'hFFFFFFFF, 0),          // R11
    st(K_WR, 11, 4, 32'hFFFFFFFF, 0),          // R11
    st(K_WR, 11, 24, 0, 0),                    // R11
    st(K_RD, 11, 0, 0, 0),                     // R11
    st(K_RD, 11, 24, 0, 32'hFFFFFFFF),         // R11
    st(K_WR, 10, 28, 1, 0),                    // R10
    st(K_LN, 10, 0, 32'hAAAAAAAB, 0),          // R10 edge lost
    st(K_RD, 10, 0, 0, 0),                     // R10
    st(K_IRQ, 9, 0, 0, 0),                     // R9
    st(K_WR, 10, 28, 3, 0),                    // R10
    st(K_LN, 10, 0, 32'hAAAAAAAF, 0),          // R10
    st(K_RD, 10, 0, 0, 4),                     // R10
    st(K_IRQ, 9, 0, 0, 1),                     // R9
    st(K_WR, 9, 28, 2, 0),                     // R9
    st(K_IRQ, 9, 0, 0, 0),                     // R9
    st(K_RD, 10, 0, 0, 4),                     // R10 kept
    st(K_WR, 9, 28, 3, 0),                     // R9
    st(K_IRQ, 9, 0, 0, 1),                     // R9
    st(K_RD, 10, 28, 0, 3)                     // R10
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int req, input logic [4:0] a, input logic [31:0] e);
    @(negedge clk);
    bus_addr = a;
    #2 check(req, bus_rdata, e);
  endtask

  task automatic irq_chk(input int req, input logic e);
    @(negedge clk);
    #2 check(req, {31'b0, irq_out}, {31'b0, e});
  endtask

  task automatic reset_and_check();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(1, 5'd0, 32'h0);          // R1 status
    rd(1, 5'd8, 32'h0);          // R1 enable
    rd(1, 5'd28, 32'h0);         // R1 master
    rd(1, 5'd24, 32'hFFFFFFFF);  // R1 vector
    irq_chk(1, 1'b0);            // R1 output
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    reset_and_check();
    for (int i = 0; i < N; i++) begin
      logic [74:0] e;
      e = TBL[i];
      case (e[74:73])
        K_WR:  wr(e[68:64], e[63:32]);
        K_RD:  rd(int'(e[72:69]), e[68:64], e[31:0]);
        K_LN:  begin
                 @(negedge clk);
                 lines = e[63:32];
                 repeat (4) @(negedge clk);
               end
        default: irq_chk(int'(e[72:69]), e[0]);
      endcase
    end
    // R11 misaligned access reads zero and writes nothing
    wr(5'd9, 32'h0);
    rd(11, 5'd8, 32'h80000037);
    rd(11, 5'd9, 32'h0);
    // R1 mid-run reset with level line 2 still active
    reset_and_check();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule